// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Master with Port Sizing

This block is the external bus engine of a processor. It accepts single-word and four-word burst requests from the core and turns each one into a cycle on a shared 32-bit address/data bus. Each cycle has one address phase, in which the upper address bits and a transfer-size code share the bus, followed by one or more data phases. Each data phase closes on an acknowledge, a retry or a bus error from the addressed device.

Each quarter of the physical address space is a region with its own port width (8, 16 or 32 bits) and its own turnaround gap. The width is presented on a dedicated output. The byte-enable lines are remapped so that narrow devices receive low address bits in place of the lane enables they do not need. Every data phase moves one word. On a narrow port, the device's own steering packs that word into its port using the width and byte-enable outputs. A burst visits the four words of its aligned 16-byte block. It starts at the requested word, and the order is the start index XOR 0, 1, 2, 3. After a transaction ends, the bus stays idle for the gap configured for its region.

Top module: `bus_master`

## Requirements
- R1: The address phase lasts exactly one cycle, with `ale` high and `ads_n` low. `ad_out[31:4]` carries address bits 31:4 and `ad_out[3:0]` carries the size code: 4'b0000 for a 16-byte burst, and 4'b0001, 4'b0010, 4'b0011, 4'b0100 for a 1, 2, 3 or 4 byte single transfer (`req_len` is bytes minus one).
- R2: While a transaction is in progress, `width` shows the width programmed for the region selected by address bits 31:30: 2'b00 for 8 bits, 2'b01 for 16 bits, 2'b10 for 32 bits. When idle it is 2'b00.
- R3: `be_n` is active low. On a 32-bit port, bit i is low when byte lane i is used. On a 16-bit port it is {not odd-lane-used, 1, address bit 1, not even-lane-used}. On an 8-bit port it is {1, 1, address bit 1, address bit 0}. A burst uses all lanes at offset 0. When idle, `be_n` is 4'hF.
- R4: `cip_n` is low from the address phase until the final data phase is accepted. `den_n` is low only in data phases. `dtr`/`wr_n` mark a write, `rd_n` marks a read. `ad_oe` is high in the address phase and in write data phases, and low in read data phases.
- R5: A burst produces four accepted data phases. `word_addr` is start XOR k in the k-th phase. Write data for word w is `req_wdata[32*w+31:32*w]`.
- R6: `last_n` is low only in the final data phase of a transaction (the only phase of a single transfer, the fourth of a burst).
- R7: On a read, retry (`retry_n` low) is honoured only in the first data phase and restarts the transaction from its address phase. After the first word has been accepted, retry is ignored.
- R8: On a write, retry is honoured in every data phase and restarts the whole transaction, including the words already sent, from its address phase.
- R9: A bus error (`berr_n` low) ends the transaction in that cycle with `done` and `done_err` high. Priority within a data phase is bus error, then honoured retry, then acknowledge.
- R10: After `done`, `req_ready` stays low for exactly the number of cycles in the region's programmed gap. The next address phase cannot start sooner.
- R11: On every acknowledged read data phase, `rd_valid` pulses with `rd_data` equal to `ad_in` and `rd_word` equal to the word index.
- R12: After reset the bus is idle: `req_ready` is high, `cip_n`, `den_n`, `last_n` and `ads_n` are high, `ale` is low and `be_n` is 4'hF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_width | input | 2*N_REGIONS | Per-region port width code |
| cfg_gap | input | GAP_W*N_REGIONS | Per-region turnaround gap in cycles |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_burst | input | 1 | 1 = four-word burst |
| req_addr | input | 32 | Byte address |
| req_len | input | 2 | Single transfer bytes minus one |
| req_wdata | input | 128 | Write words, word w at bits 32w+31:32w |
| rd_valid | output | 1 | Read word accepted this cycle |
| rd_word | output | 2 | Word index of the read word |
| rd_data | output | 32 | Read word |
| done | output | 1 | Transaction finished this cycle |
| done_err | output | 1 | Transaction finished on bus error |
| ad_out | output | 32 | Address/data bus, driven value |
| ad_oe | output | 1 | Address/data bus output enable |
| ad_in | input | 32 | Address/data bus, received value |
| ale | output | 1 | Address latch enable |
| ads_n | output | 1 | Address strobe, active low |
| cip_n | output | 1 | Cycle in progress, active low |
| den_n | output | 1 | Data phase, active low |
| dtr | output | 1 | Direction, high for write |
| rd_n | output | 1 | Read cycle, active low |
| wr_n | output | 1 | Write cycle, active low |
| last_n | output | 1 | Final data phase, active low |
| word_addr | output | 2 | Word within block (address bits 3:2) |
| width | output | 2 | Port width of the current region |
| be_n | output | 4 | Byte enables / low address bits |
| ack_n | input | 1 | Acknowledge, active low |
| retry_n | input | 1 | Retry, active low |
| berr_n | input | 1 | Bus error, active low |

## Verification
The assertions cover the phase structure on every cycle: a single-cycle address phase always followed by a data phase, a legal size code, `cip_n` covering every phase, bus drive direction matching the cycle type, and `last_n` and `rd_valid` appearing only inside data phases. They also check that narrow ports never enable the top lanes, and that completion or error returns the bus to idle with no address phase in the next cycle. The scenarios are needed for the rest: the sub-block word order, the asymmetric retry rules for reads and writes, the exact byte-enable remapping for each width, and the length of the turnaround gap. A cycle-level reference model compares every output in every cycle against these scenarios.

// File: rtl/bus_master_pkg.sv
// Shared types and helpers for the multiplexed bus master.
// Assumes a 32-bit address/data bus and a four-word burst block.
package bus_master_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2
    } bus_state_e;

    localparam logic [1:0] PW_8  = 2'b00;
    localparam logic [1:0] PW_16 = 2'b01;
    localparam logic [1:0] PW_32 = 2'b10;

    localparam int BUS_W       = 32;
    localparam int BURST_WORDS = 4;

    // Size code placed on the low bus lines during the address phase.
    function automatic logic [3:0] size_code(input logic burst, input logic [1:0] len);
        logic [2:0] nb;
        nb = {1'b0, len} + 3'd1;
        return burst ? 4'b0000 : {1'b0, nb};
    endfunction

endpackage

// File: rtl/bus_region_sel.sv
// Region lookup: picks port width and turnaround gap for an address.
// Assumes regions split the space evenly by the top address bits.
module bus_region_sel #(
    parameter int N_REGIONS = 4,
    parameter int GAP_W     = 3,
    localparam int RB       = (N_REGIONS > 1) ? $clog2(N_REGIONS) : 1
) (
    input  logic [RB-1:0]              region,
    input  logic [2*N_REGIONS-1:0]     cfg_width,
    input  logic [GAP_W*N_REGIONS-1:0] cfg_gap,
    output logic [1:0]                 width,
    output logic [GAP_W-1:0]           gap
);

    logic [N_REGIONS-1:0]     hit;
    logic [1:0]               w_term [N_REGIONS];
    logic [GAP_W-1:0]         g_term [N_REGIONS];

    // One-hot region match with masked per-region fields.
    for (genvar i = 0; i < N_REGIONS; i++) begin : g_reg
        assign hit[i]    = (region == RB'(i));
        assign w_term[i] = hit[i] ? cfg_width[2*i +: 2] : 2'b00;
        assign g_term[i] = hit[i] ? cfg_gap[GAP_W*i +: GAP_W] : '0;
    end

    // OR-reduce the masked fields into the selected values.
    always_comb begin
        width = 2'b00;
        gap   = '0;
        for (int i = 0; i < N_REGIONS; i++) begin
            width = width | w_term[i];
            gap   = gap | g_term[i];
        end
    end

endmodule

// File: rtl/bus_lane_map.sv
// Byte-enable generator: maps used byte lanes onto the four enable
// pins according to port width. Assumes a single transfer stays
// inside one word; bursts use all lanes at offset zero.
module bus_lane_map
    import bus_master_pkg::*;
(
    input  logic [1:0] width,
    input  logic       burst,
    input  logic [1:0] offset,
    input  logic [1:0] len,
    output logic [3:0] be_n
);

    logic [3:0] low_mask;
    logic [1:0] eff_off;
    logic [7:0] span;
    logic [3:0] used;

    // Lanes touched by the transfer.
    always_comb begin
        low_mask = burst ? 4'hF : (4'hF >> (2'd3 - len));
        eff_off  = burst ? 2'b00 : offset;
        span     = {4'b0000, low_mask} << eff_off;
        used     = span[3:0];
    end

    // Pin encoding per port width.
    always_comb begin
        case (width)
            PW_8:    be_n = {2'b11, eff_off};
            PW_16:   be_n = {~(used[3] | used[1]), 1'b1, eff_off[1], ~(used[2] | used[0])};
            default: be_n = ~used;
        endcase
    end

endmodule

// File: rtl/bus_master.sv
// Multiplexed address/data bus master. Turns single and four-word
// burst requests into an address phase plus data phases, applies
// per-region port width and turnaround gap, and terminates phases on
// acknowledge, retry or bus error. Assumes requests are held until
// accepted and response inputs are synchronous to clk.
module bus_master
    import bus_master_pkg::*;
#(
    parameter int N_REGIONS = 4,
    parameter int GAP_W     = 3,
    localparam int RB       = (N_REGIONS > 1) ? $clog2(N_REGIONS) : 1,
    localparam int WD_W     = BUS_W * BURST_WORDS,
    localparam int WI_W     = $clog2(BURST_WORDS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [2*N_REGIONS-1:0]     cfg_width,
    input  logic [GAP_W*N_REGIONS-1:0] cfg_gap,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic                       req_write,
    input  logic                       req_burst,
    input  logic [BUS_W-1:0]           req_addr,
    input  logic [1:0]                 req_len,
    input  logic [WD_W-1:0]            req_wdata,
    output logic                       rd_valid,
    output logic [WI_W-1:0]            rd_word,
    output logic [BUS_W-1:0]           rd_data,
    output logic                       done,
    output logic                       done_err,
    output logic [BUS_W-1:0]           ad_out,
    output logic                       ad_oe,
    input  logic [BUS_W-1:0]           ad_in,
    output logic                       ale,
    output logic                       ads_n,
    output logic                       cip_n,
    output logic                       den_n,
    output logic                       dtr,
    output logic                       rd_n,
    output logic                       wr_n,
    output logic                       last_n,
    output logic [WI_W-1:0]            word_addr,
    output logic [1:0]                 width,
    output logic [3:0]                 be_n,
    input  logic                       ack_n,
    input  logic                       retry_n,
    input  logic                       berr_n
);

    bus_state_e         state;
    logic               r_write, r_burst;
    logic [BUS_W-1:0]   r_addr;
    logic [1:0]         r_len;
    logic [WD_W-1:0]    r_wdata;
    logic [WI_W-1:0]    k;
    logic [GAP_W-1:0]   gap_cnt;

    logic [1:0]         reg_width;
    logic [GAP_W-1:0]   reg_gap;
    logic [3:0]         lane_be_n;

    logic in_addr, in_data, busy, accept, last_phase;
    logic berr_hit, retry_hon, ack_ok;
    logic [WI_W-1:0] cur_word;

    bus_region_sel #(.N_REGIONS(N_REGIONS), .GAP_W(GAP_W)) u_region (
        .region    (r_addr[BUS_W-1 -: RB]),
        .cfg_width (cfg_width),
        .cfg_gap   (cfg_gap),
        .width     (reg_width),
        .gap       (reg_gap)
    );

    bus_lane_map u_lanes (
        .width  (reg_width),
        .burst  (r_burst),
        .offset (r_addr[1:0]),
        .len    (r_len),
        .be_n   (lane_be_n)
    );

    // Phase decode and data-phase termination priority.
    always_comb begin
        in_addr    = (state == ST_ADDR);
        in_data    = (state == ST_DATA);
        busy       = in_addr | in_data;
        req_ready  = (state == ST_IDLE) && (gap_cnt == '0);
        accept     = req_valid && req_ready;
        cur_word   = r_addr[3:2] ^ k;
        last_phase = r_burst ? (k == WI_W'(BURST_WORDS - 1)) : 1'b1;
        berr_hit   = in_data && !berr_n;
        retry_hon  = in_data && berr_n && !retry_n && (r_write || k == '0);
        ack_ok     = in_data && berr_n && !retry_hon && !ack_n;
        done       = berr_hit || (ack_ok && last_phase);
        done_err   = berr_hit;
        rd_valid   = ack_ok && !r_write;
        rd_word    = cur_word;
        rd_data    = ad_in;
    end

    // Bus pin values for the current phase.
    always_comb begin
        ale       = in_addr;
        ads_n     = ~in_addr;
        cip_n     = ~busy;
        den_n     = ~in_data;
        dtr       = busy && r_write;
        rd_n      = ~(busy && !r_write);
        wr_n      = ~(busy && r_write);
        last_n    = ~(in_data && last_phase);
        word_addr = busy ? cur_word : '0;
        width     = busy ? reg_width : 2'b00;
        be_n      = busy ? lane_be_n : 4'hF;
        ad_oe     = in_addr || (in_data && r_write);
        if (in_addr)
            ad_out = {r_addr[BUS_W-1:4], size_code(r_burst, r_len)};
        else if (in_data && r_write)
            ad_out = r_wdata[BUS_W*cur_word +: BUS_W];
        else
            ad_out = '0;
    end

    // Cycle state machine and request capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            r_write <= 1'b0;
            r_burst <= 1'b0;
            r_addr  <= '0;
            r_len   <= '0;
            r_wdata <= '0;
            k       <= '0;
        end else begin
            case (state)
                ST_IDLE: if (accept) begin
                    r_write <= req_write;
                    r_burst <= req_burst;
                    r_addr  <= req_addr;
                    r_len   <= req_len;
                    r_wdata <= req_wdata;
                    k       <= '0;
                    state   <= ST_ADDR;
                end
                ST_ADDR: state <= ST_DATA;
                ST_DATA: begin
                    if (done) begin
                        state <= ST_IDLE;
                    end else if (retry_hon) begin
                        state <= ST_ADDR;
                        k     <= '0;
                    end else if (ack_ok) begin
                        k <= k + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Turnaround gap counter, loaded when a transaction ends.
    always_ff @(posedge clk) begin
        if (!rst_n)
            gap_cnt <= '0;
        else if (done)
            gap_cnt <= reg_gap;
        else if (gap_cnt != '0)
            gap_cnt <= gap_cnt - 1'b1;
    end

endmodule

// File: rtl/bus_master_chk.sv
// Protocol checker for bus_master, attached by bind. Observes the
// bus pins and the completion outputs only.
module bus_master_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ale,
    input logic        cip_n,
    input logic        den_n,
    input logic        rd_n,
    input logic        wr_n,
    input logic        last_n,
    input logic        ad_oe,
    input logic [31:0] ad_out,
    input logic [1:0]  width,
    input logic [3:0]  be_n,
    input logic        done,
    input logic        done_err,
    input logic        rd_valid
);

    p_addr_single_cycle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);

    p_size_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (ad_oe && ad_out[3:0] <= 4'd4));

    p_narrow_be_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cip_n && width == 2'b00) |-> (be_n[3:2] == 2'b11));

    p_data_follows_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !den_n);

    p_cip_cover_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ale || !den_n) |-> !cip_n);

    p_write_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!den_n && !wr_n) |-> ad_oe);

    p_read_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!den_n && !rd_n) |-> !ad_oe);

    p_last_in_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !last_n |-> !den_n);

    p_err_ends_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_err |=> den_n);

    p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (cip_n && !ale));

    p_rdv_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (!rd_n && !den_n));

endmodule

bind bus_master bus_master_chk u_chk (.*);

// File: tb/bus_master_test.sv
// Bench for bus_master: behavioural cycle model compared every cycle,
// plus scenario checks on observed port activity.
module bus_master_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [7:0]   cfg_width;
    logic [11:0]  cfg_gap;
    logic         req_valid = 1'b0, req_write = 1'b0, req_burst = 1'b0;
    logic [31:0]  req_addr = '0;
    logic [1:0]   req_len = '0;
    logic [127:0] req_wdata = '0;
    logic         req_ready, rd_valid, done, done_err;
    logic [1:0]   rd_word, word_addr, width;
    logic [31:0]  rd_data, ad_out, ad_in;
    logic         ad_oe, ale, ads_n, cip_n, den_n, dtr, rd_n, wr_n, last_n;
    logic [3:0]   be_n;
    logic         ack_n, retry_n, berr_n;

    always #2 clk = ~clk;

    int bw [4] = '{2, 1, 0, 2};
    int bg [4] = '{0, 2, 5, 1};
    assign cfg_width = {bw[3][1:0], bw[2][1:0], bw[1][1:0], bw[0][1:0]};
    assign cfg_gap   = {bg[3][2:0], bg[2][2:0], bg[1][2:0], bg[0][2:0]};

    bus_master uut (.*);

    int checks = 0, failures = 0;
    bit finished = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Response script: 0 ack, 1 retry, 2 bus error, 3 wait, 4 retry+ack.
    int resp_q[$];

    // Model state.
    int ms = 0, mk = 0, mgap = 0, m_len = 0;
    bit m_w = 0, m_b = 0;
    logic [31:0] m_addr = '0;
    logic [127:0] m_wd = '0;
    int acc_cnt = 0, done_cnt = 0, cyc = 0;

    // Observations.
    int n_ale, n_rdv, n_den, n_done, last_word, last_gap, gcnt;
    bit seen_err, measuring;
    logic [31:0] ad_at_ale;
    logic [3:0]  be_at_ale;
    logic [1:0]  w_at_ale;
    int rd_words[$];

    task automatic clear_obs();
        n_ale = 0; n_rdv = 0; n_den = 0; n_done = 0; seen_err = 0;
        last_word = -1; rd_words.delete();
    endtask

    function automatic logic [3:0] exp_be(int w, bit burst, int off, int len);
        bit used [4];
        bit odd_u, even_u;
        logic [3:0] r;
        if (burst) off = 0;
        odd_u = 0; even_u = 0;
        for (int i = 0; i < 4; i++) begin
            used[i] = burst || (i >= off && i <= off + len);
            if (used[i] && (i % 2 == 1)) odd_u = 1;
            if (used[i] && (i % 2 == 0)) even_u = 1;
        end
        if (w == 0)      r = {2'b11, off[1:0]};
        else if (w == 1) r = {!odd_u, 1'b1, off[1], !even_u};
        else             for (int i = 0; i < 4; i++) r[i] = !used[i];
        return r;
    endfunction

    always @(negedge clk) begin
        int code, rg, start, cw, e_size;
        bit busy, last, berr, hon, ackok, e_done;
        logic [31:0] e_ad;
        code = -1;
        if (ms == 2) code = (resp_q.size() > 0) ? resp_q.pop_front() : 0;
        ack_n   = !(code == 0 || code == 4);
        retry_n = !(code == 1 || code == 4);
        berr_n  = !(code == 2);
        ad_in   = {16'hC0DE, cyc[15:0]};
        cyc++;
        #1;
        if (!rst_n) begin
            ms = 0; mk = 0; mgap = 0;
        end else begin
            rg    = int'(m_addr[31:30]);
            start = int'(m_addr[3:2]);
            cw    = start ^ mk;
            busy  = (ms != 0);
            last  = m_b ? (mk == 3) : 1'b1;
            berr  = (ms == 2) && code == 2;
            hon   = (ms == 2) && !berr && (code == 1 || code == 4) && (m_w || mk == 0);
            ackok = (ms == 2) && !berr && !hon && (code == 0 || code == 4);
            e_done = berr || (ackok && last);
            e_size = m_b ? 0 : m_len + 1;
            if (ms == 1)             e_ad = {m_addr[31:4], e_size[3:0]};
            else if (ms == 2 && m_w) e_ad = m_wd[cw*32 +: 32];
            else                     e_ad = '0;

            chk("R10 req_ready", req_ready, (ms == 0 && mgap == 0));
            chk("R1 ale", ale, ms == 1);
            chk("R1 ads_n", ads_n, ms != 1);
            chk("R1 ad_out", ad_out, e_ad);
            chk("R4 ad_oe", ad_oe, (ms == 1) || (ms == 2 && m_w));
            chk("R4 cip_n", cip_n, !busy);
            chk("R4 den_n", den_n, ms != 2);
            chk("R4 dtr", dtr, busy && m_w);
            chk("R4 rd_n", rd_n, !(busy && !m_w));
            chk("R4 wr_n", wr_n, !(busy && m_w));
            chk("R6 last_n", last_n, !(ms == 2 && last));
            chk("R5 word_addr", word_addr, busy ? cw : 0);
            chk("R2 width", width, busy ? bw[rg] : 0);
            chk("R3 be_n", be_n, busy ? exp_be(bw[rg], m_b, int'(m_addr[1:0]), m_len) : 4'hF);
            chk("R11 rd_valid", rd_valid, ackok && !m_w);
            chk("R9 done", done, e_done);
            chk("R9 done_err", done_err, berr);
            if (ackok && !m_w) begin
                chk("R11 rd_data", rd_data, ad_in);
                chk("R5 rd_word", rd_word, cw);
            end

            // Port observations for scenario checks.
            if (measuring) begin
                if (!req_ready) gcnt++;
                else begin last_gap = gcnt; measuring = 0; end
            end
            if (ale) begin n_ale++; ad_at_ale = ad_out; be_at_ale = be_n; w_at_ale = width; end
            if (!den_n) n_den++;
            if (rd_valid) begin n_rdv++; rd_words.push_back(int'(rd_word)); end
            if (done) begin
                n_done++; measuring = 1; gcnt = 0;
                if (done_err) seen_err = 1;
                if (!last_n) last_word = int'(word_addr);
            end

            // Model step (effect of the coming rising edge).
            case (ms)
                0: if (mgap > 0) mgap--;
                   else if (req_valid) begin
                       m_w = req_write; m_b = req_burst; m_addr = req_addr;
                       m_len = int'(req_len); m_wd = req_wdata; mk = 0; ms = 1; acc_cnt++;
                   end
                1: ms = 2;
                default: begin
                    if (e_done) begin ms = 0; mgap = bg[rg]; done_cnt++; end
                    else if (hon) begin ms = 1; mk = 0; end
                    else if (ackok) mk++;
                end
            endcase
        end
    end

    task automatic run_txn(input bit w, input bit b, input logic [31:0] a,
                           input logic [1:0] len, input logic [127:0] wd);
        int a0, d0;
        @(negedge clk);
        clear_obs();
        a0 = acc_cnt; d0 = done_cnt;
        req_valid = 1; req_write = w; req_burst = b; req_addr = a;
        req_len = len; req_wdata = wd;
        while (acc_cnt == a0) @(negedge clk);
        req_valid = 0;
        while (done_cnt == d0) @(negedge clk);
        repeat (8) @(negedge clk);
    endtask

    initial begin
        measuring = 0; last_gap = -1; gcnt = 0;
        clear_obs();
        repeat (4) @(negedge clk);
        rst_n = 1;
        #1.5;
        chk("R12 ready after reset", req_ready, 1);
        chk("R12 cip_n idle", cip_n, 1);
        chk("R12 ale idle", ale, 0);
        chk("R12 ads_n idle", ads_n, 1);
        chk("R12 den_n idle", den_n, 1);
        chk("R12 last_n idle", last_n, 1);
        chk("R12 be_n idle", be_n, 4'hF);

        // Single 4-byte read, 32-bit region, no gap.
        run_txn(0, 0, 32'h0000_0104, 2'd3, '0);
        chk("R1 size code 4 bytes", ad_at_ale[3:0], 4'h4);
        chk("R1 upper address", ad_at_ale[31:4], 28'h000_0010);
        chk("R2 32-bit width", w_at_ale, 2'b10);
        chk("R11 one read word", n_rdv, 1);
        chk("R10 zero gap", last_gap, 0);

        // Single 1-byte write, 16-bit region, lane 2.
        run_txn(1, 0, 32'h4000_0022, 2'd0, {4{32'h1234_5678}});
        chk("R3 16-bit be_n", be_at_ale, 4'b1110);
        chk("R2 16-bit width", w_at_ale, 2'b01);
        chk("R1 size code 1 byte", ad_at_ale[3:0], 4'h1);
        chk("R10 gap of two", last_gap, 2);

        // Single 2-byte read, 8-bit region, offset 1.
        run_txn(0, 0, 32'h8000_0011, 2'd1, '0);
        chk("R3 8-bit be_n", be_at_ale, 4'b1101);
        chk("R2 8-bit width", w_at_ale, 2'b00);
        chk("R1 size code 2 bytes", ad_at_ale[3:0], 4'h2);
        chk("R10 gap of five", last_gap, 5);

        // Burst read from word 2 with wait states.
        resp_q = '{3, 0, 0, 3, 0, 0};
        run_txn(0, 1, 32'h0000_0208, 2'd0, '0);
        chk("R1 burst size code", ad_at_ale[3:0], 4'h0);
        chk("R5 burst word count", rd_words.size(), 4);
        if (rd_words.size() == 4) begin
            chk("R5 order 0", rd_words[0], 2);
            chk("R5 order 1", rd_words[1], 3);
            chk("R5 order 2", rd_words[2], 0);
            chk("R5 order 3", rd_words[3], 1);
        end
        chk("R6 last word of burst", last_word, 1);

        // Read retry: honoured on first phase, ignored later.
        resp_q = '{1, 0, 4, 0, 0};
        run_txn(0, 1, 32'hC000_0030, 2'd0, '0);
        chk("R7 address phases", n_ale, 2);
        chk("R7 words accepted", n_rdv, 4);
        chk("R10 gap of one", last_gap, 1);

        // Write retry on third data phase restarts all four.
        resp_q = '{0, 0, 1, 0, 0, 0, 0};
        run_txn(1, 1, 32'h4000_0000, 2'd0,
                {32'hDDDD_0003, 32'hCCCC_0002, 32'hBBBB_0001, 32'hAAAA_0000});
        chk("R8 address phases", n_ale, 2);
        chk("R8 data phases", n_den, 7);
        chk("R8 single completion", n_done, 1);

        // Bus error on second phase.
        resp_q = '{0, 2};
        run_txn(0, 1, 32'h0000_0000, 2'd0, '0);
        chk("R9 error reported", seen_err, 1);
        chk("R9 words before error", n_rdv, 1);
        chk("R9 data phases", n_den, 2);

        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; failures++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule